// File: doc/BRIEF.md
# Mixed-Sign Multiplier with Shared Signed Core

This block forms a 32-bit product from two operands. Signed, unsigned and mixed-sign products all go through one signed multiply core that is one bit wider than the operands. Before the multiply, each operand is widened by one bit. That top bit copies the operand's sign bit when the selected mode treats the operand as signed, and is zero when the mode treats it as unsigned. Because the widened operands are always non-negative for unsigned inputs, a single signed array gives the correct result for every pairing.

A 3-bit mode code picks the interpretation of each operand. It can also replace operand B with a short zero-extended literal, or restrict both operands to their low byte. The caller pulses `start` with the operands and the mode. One cycle later `prod_vld` pulses and `prod` carries the result. `prod` then holds that value until the next `start`.

Top module: `mixed_sign_mul`

## Requirements
- R1: While `rst_n` is low, `prod` is 0 and `prod_vld` is 0.
- R2: `prod_vld` is 1 in the cycle after a cycle with `start` high, and 0 in the cycle after a cycle with `start` low.
- R3: Mode 0: `prod` is the low 32 bits of signed `op_a` times signed `op_b` (two's complement).
- R4: Mode 1: `prod` is unsigned `op_a` times unsigned `op_b`.
- R5: Mode 2: `prod` is the low 32 bits of signed `op_a` times the zero-extended 5-bit `lit`. `op_b` has no effect.
- R6: Mode 3: `prod` is the low 32 bits of unsigned `op_a` times signed `op_b`.
- R7: Mode 4: `prod` is unsigned `op_a` times the zero-extended `lit`. `op_b` has no effect, and `prod` bits 31:21 are 0.
- R8: Mode 5: `prod` is the low 32 bits of signed `op_a` times unsigned `op_b`.
- R9: Mode 6: `prod` is `op_a[7:0]` times `op_b[7:0]`, both unsigned, zero-extended to 32 bits. The upper operand bytes have no effect, and `prod` bits 31:16 are 0.
- R10: Mode 7 (reserved) gives the same result as mode 1.
- R11: While `start` is low, `prod` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiply with the current operands and mode |
| mode | input | 3 | Operand interpretation code (0..7) |
| op_a | input | 16 | Operand A |
| op_b | input | 16 | Operand B |
| lit | input | 5 | Short literal, replaces B in modes 2 and 4 |
| prod | output | 32 | Registered product |
| prod_vld | output | 1 | One-cycle pulse when `prod` is updated |

## Verification
The bench builds two copies of the block.

The first copy is shrunk to 6-bit operands, a 2-bit literal and a 3-bit byte field. At that size every operand pair can be applied in all eight modes, so every sign-extension choice meets every boundary value: the most negative value, all ones, and zero. In the literal modes the sweep inverts `op_b`, which shows that B is ignored. After each product the sweep scrambles the inputs with `start` low, which shows that the result holds.

The second copy uses the default widths. It is driven with corner operands such as 0x8000, 0x7FFF and 0xFFFF in every mode, which checks the full 32-bit truncation.

// File: rtl/mixed_sign_mul.sv
module mixed_sign_mul #(
  parameter int DATA_W = 16,
  parameter int LIT_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2:0]            mode,
  input  logic [DATA_W-1:0]     op_a,
  input  logic [DATA_W-1:0]     op_b,
  input  logic [LIT_W-1:0]      lit,
  output logic [2*DATA_W-1:0]   prod,
  output logic                  prod_vld
);
  localparam int CORE_W = DATA_W + 1;
  localparam int OUT_W  = 2 * DATA_W;

  localparam logic [2:0] M_SS   = 3'd0;
  localparam logic [2:0] M_UU   = 3'd1;
  localparam logic [2:0] M_SL   = 3'd2;
  localparam logic [2:0] M_US   = 3'd3;
  localparam logic [2:0] M_UL   = 3'd4;
  localparam logic [2:0] M_SU   = 3'd5;
  localparam logic [2:0] M_BYTE = 3'd6;

  logic a_sgn, b_sgn, use_lit, use_byte;

  always_comb begin
    a_sgn    = 1'b0;
    b_sgn    = 1'b0;
    use_lit  = 1'b0;
    use_byte = 1'b0;
    case (mode)
      M_SS:    begin a_sgn = 1'b1; b_sgn = 1'b1; end
      M_SL:    begin a_sgn = 1'b1; use_lit = 1'b1; end
      M_US:    b_sgn = 1'b1;
      M_UL:    use_lit = 1'b1;
      M_SU:    a_sgn = 1'b1;
      M_BYTE:  use_byte = 1'b1;
      default: ;
    endcase
  end

  logic [DATA_W-1:0]        b_src;
  logic signed [CORE_W-1:0] a_core, b_core;
  logic signed [OUT_W-1:0]  a_ext, b_ext, core_lo;

  assign b_src = use_lit ? {{(DATA_W-LIT_W){1'b0}}, lit} : op_b;

  assign a_core = use_byte ? {{(CORE_W-BYTE_W){1'b0}}, op_a[BYTE_W-1:0]}
                           : {a_sgn & op_a[DATA_W-1], op_a};
  assign b_core = use_byte ? {{(CORE_W-BYTE_W){1'b0}}, b_src[BYTE_W-1:0]}
                           : {b_sgn & b_src[DATA_W-1], b_src};

  assign a_ext   = OUT_W'(a_core);
  assign b_ext   = OUT_W'(b_core);
  assign core_lo = a_ext * b_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod     <= '0;
      prod_vld <= 1'b0;
    end else begin
      prod_vld <= start;
      if (start) prod <= core_lo;
    end
  end

  a_r2_vld_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> prod_vld);
  a_r2_no_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !prod_vld);
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(prod));
  a_r9_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == M_BYTE) |=> prod[OUT_W-1:2*BYTE_W] == '0);
  a_r7_lit_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == M_UL) |=> prod[OUT_W-1:DATA_W+LIT_W] == '0);
endmodule

// File: tb/mixed_sign_mul_bench.sv
module mixed_sign_mul_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        s_start = 1'b0;
  logic [2:0]  s_mode = '0;
  logic [5:0]  s_a = '0, s_b = '0;
  logic [1:0]  s_lit = '0;
  logic [11:0] s_prod;
  logic        s_vld;

  logic        f_start = 1'b0;
  logic [2:0]  f_mode = '0;
  logic [15:0] f_a = '0, f_b = '0;
  logic [4:0]  f_lit = '0;
  logic [31:0] f_prod;
  logic        f_vld;

  mixed_sign_mul #(.DATA_W(6), .LIT_W(2), .BYTE_W(3)) u_mixed_sign_mul (
    .clk(clk), .rst_n(rst_n), .start(s_start), .mode(s_mode), .op_a(s_a),
    .op_b(s_b), .lit(s_lit), .prod(s_prod), .prod_vld(s_vld));

  mixed_sign_mul u_mixed_sign_mul_full (
    .clk(clk), .rst_n(rst_n), .start(f_start), .mode(f_mode), .op_a(f_a),
    .op_b(f_b), .lit(f_lit), .prod(f_prod), .prod_vld(f_vld));

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  string rq [8] = '{"R3", "R4", "R5", "R6", "R7", "R8", "R9", "R10"};

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic longint sx(input longint v, input int w);
    return v[w-1] ? v - (longint'(1) << w) : v;
  endfunction

  function automatic longint exp_prod(input int w, input int bw, input int m,
                                      input longint a, input longint b, input longint l);
    longint x, y;
    case (m)
      0: begin x = sx(a, w); y = sx(b, w); end
      2: begin x = sx(a, w); y = l; end
      3: begin x = a; y = sx(b, w); end
      4: begin x = a; y = l; end
      5: begin x = sx(a, w); y = b; end
      6: begin x = a % (longint'(1) << bw); y = b % (longint'(1) << bw); end
      default: begin x = a; y = b; end
    endcase
    return (x * y) & ((longint'(1) << (2 * w)) - 1);
  endfunction

  initial begin
    longint ex, hold;
    longint fv [6] = '{0, 1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    bit first;
    repeat (3) @(negedge clk);
    chk(s_prod == 0 && s_vld == 0, "R1", {s_vld, s_prod}, 0);
    chk(f_prod == 0 && f_vld == 0, "R1", {f_vld, f_prod}, 0);
    rst_n = 1'b1;

    first = 1'b1;
    hold = 0;
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 64; a++) begin
        for (int b = 0; b < 64; b++) begin
          @(negedge clk);
          if (!first) begin
            chk(s_vld == 0, "R2", s_vld, 0);
            chk(s_prod == hold, "R11", s_prod, hold);
          end
          first = 1'b0;
          s_start = 1'b1;
          s_mode = 3'(m);
          s_a = 6'(a);
          s_lit = 2'(b);
          s_b = (m == 2 || m == 4) ? ~6'(b) : 6'(b);
          ex = exp_prod(6, 3, m, a, longint'(s_b), longint'(s_lit));
          @(negedge clk);
          chk(s_vld == 1, "R2", s_vld, 1);
          chk(s_prod == ex, rq[m], s_prod, ex);
          hold = ex;
          s_start = 1'b0;
          s_a = ~s_a;
          s_b = ~s_b;
          s_lit = ~s_lit;
          s_mode = ~s_mode;
        end
      end
    end

    first = 1'b1;
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          @(negedge clk);
          if (!first) begin
            chk(f_vld == 0, "R2", f_vld, 0);
            chk(f_prod == hold, "R11", f_prod, hold);
          end
          first = 1'b0;
          f_start = 1'b1;
          f_mode = 3'(m);
          f_a = 16'(fv[i]);
          f_b = 16'(fv[j]);
          f_lit = 5'(fv[j] + i);
          ex = exp_prod(16, 8, m, fv[i], fv[j], longint'(f_lit));
          @(negedge clk);
          chk(f_vld == 1, "R2", f_vld, 1);
          chk(f_prod == ex, rq[m], f_prod, ex);
          hold = ex;
          f_start = 1'b0;
          f_a = ~f_a;
          f_b = ~f_b;
          f_lit = ~f_lit;
          f_mode = ~f_mode;
        end
      end
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(f_prod == 0 && f_vld == 0, "R1", {f_vld, f_prod}, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule